// File: doc/BRIEF.md
# BCD Clock Calendar With Century

This core keeps wall-clock time and calendar date as packed BCD fields: seconds, minutes, hours, day of week, day of month, month and two-digit year. A century flag sits beside the hours field. Time moves forward by one second for each accepted pulse on a 1 Hz tick input. A halt flag stored with the seconds field freezes counting and is also driven out as a pin, so the oscillator outside the core can be stopped. The core handles month lengths, leap years and the century flip.

A bus front end reaches the core through a simple register port with seven byte-wide registers. It supplies an address, write data and a write strobe, and it gets combinational read data. While the front end holds the read-busy flag, the visible registers do not change, so a multi-byte read returns one consistent time. Ticks that arrive during that window are counted and are not lost. When the flag drops, the registers advance by one second per clock until the backlog is gone. A register write replaces the time at once and throws away any backlog.

Top module: `rtc_bcd_core`

## Requirements
- R1: Seconds (reg 0 bits 6:0) and minutes (reg 1 bits 6:0) count in BCD from 00 to 59, and 59 wraps to 00 with a carry. Hours (reg 2 bits 5:0) count from 00 to 23, and 23 wraps to 00 with a carry into the date.
- R2: When reg 0 bit 7 (halt) is 1, ticks are ignored and `osc_halt` is 1. Clearing the bit resumes counting from the stored time.
- R3: The register layout is as follows. Reg 3 holds the day of week in bits 2:0. Reg 4 holds the date in bits 5:0, reg 5 the month in bits 4:0 and reg 6 the year in bits 7:0. Reg 1 bit 7 and all bits above each field read 0. Address 7 reads 0x00, and writes to it are ignored.
- R4: At each midnight rollover the day of week goes up by one, and 7 wraps to 1.
- R5: April, June, September and November end after day 30. All other months except February end after day 31.
- R6: A year whose BCD value is divisible by 4, including 00, is a leap year, and February 28 is followed by February 29. In any other year February 28 is followed by March 1.
- R7: After December 31, the month goes to 01 and the date to 01. Year 99 becomes 00.
- R8: Reg 2 bit 6 is the century flag. When reg 2 bit 7 (century enable) is 1, the flag inverts when the year wraps from 99 to 00. When the enable is 0, the flag never changes on its own.
- R9: While `rd_busy` is 1, the registers do not change on ticks, but each tick is counted. After `rd_busy` falls, the registers advance by one second per clock until every counted tick has been applied.
- R10: A write shows up in the register at the next clock edge and discards any counted ticks that have not been applied.
- R11: After reset the registers read 00, 00, 00, 01, 01, 01, 00 for addresses 0 to 6, and `osc_halt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| rd_busy | input | 1 | Bus read in progress; holds the visible registers |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| osc_halt | output | 1 | Copy of the halt flag |

## Verification
A table of start times is written in and then advanced by a single tick. The table covers a carry that stops at the seconds tens digit, a carry that reaches the hours, and a midnight rollover with day-of-week wrap. It also covers the ends of 30-day and 31-day months, and February ends in a common year, a leap year and year 00. Three year wraps use different enable and flag settings, which tells whether the century flag follows the enable bit. Directed tests then check the halt flag and masked or unused register bits. Further tests hold reads with ticks arriving, then release them and count the catch-up steps. A last test writes during a held read, which shows whether the backlog is dropped or replayed.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic       stop;
        logic [6:0] sec;
        logic [6:0] min;
        logic       ceb;
        logic       cb;
        logic [5:0] hr;
        logic [2:0] dow;
        logic [5:0] date;
        logic [4:0] mon;
        logic [7:0] yr;
    } rtc_time_t;

    localparam rtc_time_t RESET_TIME = '{stop: 1'b0, sec: 7'h00, min: 7'h00,
        ceb: 1'b0, cb: 1'b0, hr: 6'h00, dow: 3'd1, date: 6'h01, mon: 5'h01, yr: 8'h00};

    function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // 10 mod 4 == 2, so value mod 4 == (2*tens_lsb + ones) mod 4
    function automatic logic is_leap(input logic [7:0] yr);
        logic [4:0] s;
        s = {3'b000, yr[4], 1'b0} + {1'b0, yr[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

    function automatic logic [5:0] month_last(input logic [4:0] mon, input logic [7:0] yr);
        logic [5:0] r;
        case (mon)
            5'h02:                      r = is_leap(yr) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
            default:                    r = 6'h31;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/rtc_step.sv
module rtc_step
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    output rtc_time_t nxt
);
    logic [7:0] s8, m8, h8, d8, mo8, y8;

    always_comb begin
        s8  = bcd_inc8({1'b0, cur.sec});
        m8  = bcd_inc8({1'b0, cur.min});
        h8  = bcd_inc8({2'b00, cur.hr});
        d8  = bcd_inc8({2'b00, cur.date});
        mo8 = bcd_inc8({3'b000, cur.mon});
        y8  = bcd_inc8(cur.yr);
        nxt = cur;
        if (cur.sec != 7'h59) begin
            nxt.sec = s8[6:0];
        end else begin
            nxt.sec = 7'h00;
            if (cur.min != 7'h59) begin
                nxt.min = m8[6:0];
            end else begin
                nxt.min = 7'h00;
                if (cur.hr != 6'h23) begin
                    nxt.hr = h8[5:0];
                end else begin
                    nxt.hr  = 6'h00;
                    nxt.dow = (cur.dow >= 3'd7) ? 3'd1 : cur.dow + 3'd1;
                    if (cur.date != month_last(cur.mon, cur.yr)) begin
                        nxt.date = d8[5:0];
                    end else begin
                        nxt.date = 6'h01;
                        if (cur.mon != 5'h12) begin
                            nxt.mon = mo8[4:0];
                        end else begin
                            nxt.mon = 5'h01;
                            if (cur.yr != 8'h99) begin
                                nxt.yr = y8;
                            end else begin
                                nxt.yr = 8'h00;
                                nxt.cb = cur.cb ^ cur.ceb;
                            end
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rtc_tick_defer.sv
module rtc_tick_defer #(
    parameter int PEND_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_ok,
    input  logic              hold,
    input  logic              flush,
    output logic              step,
    output logic [PEND_W-1:0] pend
);
    localparam logic [PEND_W-1:0] PEND_MAX  = '1;
    localparam logic [PEND_W-1:0] PEND_ONE  = {{(PEND_W-1){1'b0}}, 1'b1};
    localparam logic [PEND_W-1:0] PEND_ZERO = '0;

    logic [PEND_W-1:0] pend_q;

    assign step = !hold && !flush && (tick_ok || pend_q != PEND_ZERO);
    assign pend = pend_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            pend_q <= PEND_ZERO;
        end else if (hold) begin
            if (tick_ok && pend_q != PEND_MAX) pend_q <= pend_q + PEND_ONE;
        end else if (!tick_ok && pend_q != PEND_ZERO) begin
            pend_q <= pend_q - PEND_ONE;
        end
    end
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
    import rtc_pkg::*;
#(
    parameter int PEND_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              rd_busy,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              osc_halt
);
    rtc_time_t         tm_q, tm_nx;
    logic              adv;
    logic [PEND_W-1:0] pend_q;

    rtc_step u_step (.cur(tm_q), .nxt(tm_nx));

    rtc_tick_defer #(.PEND_W(PEND_W)) u_defer (
        .clk(clk), .rst(rst), .tick_ok(tick_1hz && !tm_q.stop),
        .hold(rd_busy), .flush(wr_en), .step(adv), .pend(pend_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tm_q <= RESET_TIME;
        end else if (wr_en) begin
            case (addr)
                3'd0: begin tm_q.stop <= wr_data[7]; tm_q.sec <= wr_data[6:0]; end
                3'd1: tm_q.min  <= wr_data[6:0];
                3'd2: begin
                    tm_q.ceb <= wr_data[7];
                    tm_q.cb  <= wr_data[6];
                    tm_q.hr  <= wr_data[5:0];
                end
                3'd3: tm_q.dow  <= wr_data[2:0];
                3'd4: tm_q.date <= wr_data[5:0];
                3'd5: tm_q.mon  <= wr_data[4:0];
                3'd6: tm_q.yr   <= wr_data;
                default: ;
            endcase
        end else if (adv) begin
            tm_q <= tm_nx;
        end
    end

    always_comb begin
        case (addr)
            3'd0:    rd_data = {tm_q.stop, tm_q.sec};
            3'd1:    rd_data = {1'b0, tm_q.min};
            3'd2:    rd_data = {tm_q.ceb, tm_q.cb, tm_q.hr};
            3'd3:    rd_data = {5'b00000, tm_q.dow};
            3'd4:    rd_data = {2'b00, tm_q.date};
            3'd5:    rd_data = {3'b000, tm_q.mon};
            3'd6:    rd_data = tm_q.yr;
            default: rd_data = 8'h00;
        endcase
    end

    assign osc_halt = tm_q.stop;
endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk
    import rtc_pkg::*;
#(
    parameter int PEND_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_1hz,
    input logic              rd_busy,
    input logic              wr_en,
    input logic              osc_halt,
    input rtc_time_t         tm,
    input logic              step,
    input logic [PEND_W-1:0] pend
);
    localparam logic [PEND_W-1:0] ONE = {{(PEND_W-1){1'b0}}, 1'b1};

    // R9
    hold_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_busy && !wr_en) |=> $stable(tm));

    // R1
    sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && tm.sec == 7'h59) |=> (tm.sec == 7'h00));

    // R2
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (osc_halt && !wr_en && pend == '0) |=> $stable(tm));

    // R8
    century_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !tm.ceb) |=> $stable(tm.cb));

    // R9
    backlog_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_busy && !wr_en && !tick_1hz && pend != '0) |=> (pend == $past(pend) - ONE));

    // R10
    backlog_wipe_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (pend == '0));
endmodule

bind rtc_bcd_core rtc_bcd_core_chk #(.PEND_W(PEND_W)) u_chk (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .rd_busy(rd_busy), .wr_en(wr_en),
    .osc_halt(osc_halt), .tm(tm_q), .step(adv), .pend(pend_q)
);

// File: tb/rtc_bcd_core_bench.sv
`timescale 1ns/1ps
module rtc_bcd_core_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic       rd_busy = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       osc_halt;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rtc_bcd_core u_rtc_bcd_core (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .rd_busy(rd_busy), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .osc_halt(osc_halt)
    );

    // {reg0..reg6 start, reg0..reg6 expected after one tick}
    localparam int NV = 14;
    localparam logic [111:0] VEC [NV] = '{
        {56'h12_34_11_03_15_06_24, 56'h13_34_11_03_15_06_24}, // R1
        {56'h09_00_00_01_01_01_00, 56'h10_00_00_01_01_01_00}, // R1
        {56'h59_59_09_02_10_04_23, 56'h00_00_10_02_10_04_23}, // R1
        {56'h59_59_23_07_10_04_23, 56'h00_00_00_01_11_04_23}, // R4
        {56'h59_59_23_03_30_04_23, 56'h00_00_00_04_01_05_23}, // R5
        {56'h59_59_23_03_30_05_23, 56'h00_00_00_04_31_05_23}, // R5
        {56'h59_59_23_03_31_01_23, 56'h00_00_00_04_01_02_23}, // R5
        {56'h59_59_23_03_28_02_23, 56'h00_00_00_04_01_03_23}, // R6
        {56'h59_59_23_03_28_02_24, 56'h00_00_00_04_29_02_24}, // R6
        {56'h59_59_23_03_28_02_96, 56'h00_00_00_04_29_02_96}, // R6
        {56'h59_59_23_03_29_02_00, 56'h00_00_00_04_01_03_00}, // R6
        {56'h59_59_23_03_31_12_99, 56'h00_00_00_04_01_01_00}, // R7
        {56'h59_59_E3_03_31_12_99, 56'h00_00_80_04_01_01_00}, // R8
        {56'h59_59_63_03_31_12_99, 56'h00_00_40_04_01_01_00}  // R8
    };

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string req);
        addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s addr %0d got %h exp %h", req, a, rd_data, exp);
        end
    endtask

    task automatic chk_halt(input logic exp, input string req);
        #1;
        checks++;
        if (osc_halt !== exp) begin
            errors++;
            $display("FAIL %s osc_halt got %b exp %b", req, osc_halt, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(3'd0, 8'h00, "R11"); chk(3'd1, 8'h00, "R11"); chk(3'd2, 8'h00, "R11");
        chk(3'd3, 8'h01, "R11"); chk(3'd4, 8'h01, "R11"); chk(3'd5, 8'h01, "R11");
        chk(3'd6, 8'h00, "R11"); chk_halt(1'b0, "R11");

        for (int i = 0; i < NV; i++) begin
            for (int j = 0; j < 7; j++) wr(3'(j), VEC[i][111-8*j -: 8]);
            tick();
            for (int j = 0; j < 7; j++) chk(3'(j), VEC[i][55-8*j -: 8], $sformatf("vector %0d", i));
        end

        // R3 masking and the unused address
        wr(3'd3, 8'hFF); chk(3'd3, 8'h07, "R3");
        wr(3'd4, 8'hFF); chk(3'd4, 8'h3F, "R3");
        wr(3'd5, 8'hFF); chk(3'd5, 8'h1F, "R3");
        wr(3'd1, 8'hD9); chk(3'd1, 8'h59, "R3");
        wr(3'd7, 8'h55); chk(3'd7, 8'h00, "R3");

        // R2 halt flag
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h90);
        tick(); tick(); tick();
        chk(3'd0, 8'h90, "R2"); chk_halt(1'b1, "R2");
        wr(3'd0, 8'h10);
        tick();
        chk(3'd0, 8'h11, "R2"); chk_halt(1'b0, "R2");

        // R9 deferred update during a read
        wr(3'd0, 8'h00);
        @(negedge clk); rd_busy = 1'b1;
        tick(); tick(); tick();
        chk(3'd0, 8'h00, "R9");
        @(negedge clk); rd_busy = 1'b0;
        repeat (4) @(negedge clk);
        chk(3'd0, 8'h03, "R9");

        // R10 write discards backlog
        @(negedge clk); rd_busy = 1'b1;
        tick(); tick();
        wr(3'd0, 8'h20);
        chk(3'd0, 8'h20, "R10");
        @(negedge clk); rd_busy = 1'b0;
        repeat (4) @(negedge clk);
        chk(3'd0, 8'h20, "R10");
        tick();
        chk(3'd0, 8'h21, "R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule